// File: doc/BRIEF.md
# Watchdog Timer with Vector-Shared Service Address

This block is a watchdog that requests a system reset when software stops servicing it. A free-running count register advances by one on every enabled clock. Its low `PRE_W` bits form a prescaler stage and the bits above them form the timeout stage. When the count reaches the terminal value for the selected rate, a one-clock reset request pulse is issued and the count restarts from zero.

Software services the watchdog by writing to one bus address. That same address returns the low byte of the reset vector when it is read, so the block also drives a small read-data path for it. The write data is never used, so it is not an input. A read at the other vector byte address marks a vector fetch, and a vector fetch clears the prescaler stage.

Counting stops while the configuration disable input is set, while the chip is in stop mode, and while a monitor-mode hold is in force. The monitor-mode hold has two forms. If monitor mode is entered with the test voltage on the interrupt pin, the hold follows the test-voltage inputs. If monitor mode is entered without that voltage, the hold is latched until the next power-on reset.

Top module: `wdg_vecsvc`

## Requirements
- R1: While `por_n_i` is low, `tmo_o` is 0 and the count is zero. The count then advances by one on each enabled rising edge.
- R2: With `cfg_rate_i`=0 (long rate), `tmo_o` goes high on the edge after the count reaches 2^LONG_W−2^PRE_W. From a zero count, this is 2^LONG_W−2^PRE_W+1 edges after counting starts.
- R3: With `cfg_rate_i`=1 (short rate), `tmo_o` goes high on the edge after the low SHORT_W bits of the count equal 2^SHORT_W−2^PRE_W.
- R4: `tmo_o` is high for exactly one cycle. The edge that raises it also clears the count to zero.
- R5: A write strobe with `addr_i` equal to `SVC_ADDR` (default 0xFFFF) clears every count bit above the low PRE_W bits. The low PRE_W bits keep their incremented value.
- R6: A read strobe with `addr_i` equal to `FETCH_ADDR` (default 0xFFFE) clears the low PRE_W count bits.
- R7: A write strobe to any other address has no effect on the timeout.
- R8: While `rd_i` is high and `addr_i` equals `SVC_ADDR`, `rdata_en_o` is 1 and `rdata_o` equals `vec_lo_i`. At all other times both are 0.
- R9: While `cfg_dis_i` is 1, the count holds and `tmo_o` stays 0.
- R10: A change of `cfg_rate_i` applies to the count already reached, from the next edge.
- R11: For `lpm_i`, 2'b01 means wait and 2'b10 means stop. Wait counts and can time out like run mode (2'b00). Stop holds the count and keeps `tmo_o` at 0.
- R12: If `mon_entry_i` is high on an edge while `tst_irq_i` is 1, counting is held from the next edge. The hold lasts as long as `tst_irq_i` or `tst_rst_i` is 1.
- R13: If `mon_entry_i` is high on an edge while `tst_irq_i` is 0, counting is held from the next edge until `por_n_i` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_n_i | input | 1 | Power-on reset, active low, asynchronous |
| addr_i | input | ADDR_W | Bus address |
| rd_i | input | 1 | Bus read strobe |
| wr_i | input | 1 | Bus write strobe |
| vec_lo_i | input | DATA_W | Low byte of the reset vector from its storage |
| rdata_o | output | DATA_W | Read data for the shared address |
| rdata_en_o | output | 1 | Read data valid for the shared address |
| cfg_dis_i | input | 1 | Watchdog disable configuration bit |
| cfg_rate_i | input | 1 | Rate select: 0 long, 1 short |
| lpm_i | input | 2 | Low-power mode: 00 run, 01 wait, 10 stop |
| mon_entry_i | input | 1 | Pulse on monitor-mode entry |
| tst_irq_i | input | 1 | Test voltage present on the interrupt pin |
| tst_rst_i | input | 1 | Test voltage present on the reset pin |
| tmo_o | output | 1 | Reset request pulse |

## Verification
The read path is combinational, so `rdata_o` and `rdata_en_o` are checked in the same cycle that the bus is driven. Every timeout result is due a computed number of rising edges after a known stimulus edge. That number is the distance from the count value just after that edge to the terminal value, plus one edge for the registered pulse. The bench drives inputs and samples outputs on falling edges, and counts edges one by one until `tmo_o` rises. It then compares the count with the figure derived from R2, R3, R5, R6, R10 and R11. Stop, disable and monitor holds are checked by running hundreds of edges with no pulse, then measuring the delay that remains once the hold is released.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [1:0] {
        LPM_RUN  = 2'b00,
        LPM_WAIT = 2'b01,
        LPM_STOP = 2'b10
    } lpm_e;

    typedef struct packed {
        logic svc;    // service write at the shared address
        logic fetch;  // vector fetch read
        logic vsel;   // read of the shared address
    } bus_hit_t;

endpackage

// File: rtl/wdg_bus_dec.sv
module wdg_bus_dec
    import wdg_pkg::*;
#(
    parameter int unsigned        ADDR_W     = 16,
    parameter logic [ADDR_W-1:0]  SVC_ADDR   = '1,
    parameter logic [ADDR_W-1:0]  FETCH_ADDR = {{(ADDR_W-1){1'b1}}, 1'b0}
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    output bus_hit_t          hit_o
);
    logic at_svc;
    logic at_fetch;

    always_comb begin
        at_svc      = (addr_i == SVC_ADDR);
        at_fetch    = (addr_i == FETCH_ADDR);
        hit_o.svc   = wr_i & at_svc;
        hit_o.vsel  = rd_i & at_svc;
        hit_o.fetch = rd_i & at_fetch;
    end
endmodule

// File: rtl/wdg_mon_gate.sv
module wdg_mon_gate (
    input  logic clk_i,
    input  logic por_n_i,
    input  logic mon_entry_i,
    input  logic tst_irq_i,
    input  logic tst_rst_i,
    output logic blocked_o
);
    typedef struct packed {
        logic hold;   // follows the test-voltage pins
        logic latch;  // kept until power-on reset
    } mon_st_t;

    mon_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.hold && !tst_irq_i && !tst_rst_i) begin
            st_d.hold = 1'b0;
        end
        if (mon_entry_i) begin
            if (tst_irq_i) begin
                st_d.hold = 1'b1;
            end else begin
                st_d.latch = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign blocked_o = st_q.hold | st_q.latch;
endmodule

// File: rtl/wdg_count.sv
module wdg_count #(
    parameter int unsigned PRE_W   = 4,
    parameter int unsigned SHORT_W = 13,
    parameter int unsigned LONG_W  = 18
) (
    input  logic clk_i,
    input  logic por_n_i,
    input  logic en_i,
    input  logic rate_i,
    input  logic svc_i,
    input  logic fetch_i,
    output logic tmo_o
);
    localparam int unsigned HI_W = LONG_W - PRE_W;
    localparam logic [LONG_W-1:0]  TERM_LONG  = {{HI_W{1'b1}}, {PRE_W{1'b0}}};
    localparam logic [SHORT_W-1:0] TERM_SHORT = {{(SHORT_W-PRE_W){1'b1}}, {PRE_W{1'b0}}};

    typedef struct packed {
        logic [LONG_W-1:0] cnt;
        logic              pulse;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    at_term;

    always_comb begin
        if (rate_i) begin
            at_term = (st_q.cnt[SHORT_W-1:0] == TERM_SHORT);
        end else begin
            at_term = (st_q.cnt == TERM_LONG);
        end

        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (en_i) begin
            if (at_term) begin
                st_d.cnt   = '0;
                st_d.pulse = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (svc_i) begin
            st_d.cnt[LONG_W-1:PRE_W] = '0;
        end
        if (fetch_i) begin
            st_d.cnt[PRE_W-1:0] = '0;
        end
    end

    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tmo_o = st_q.pulse;
endmodule

// File: rtl/wdg_vecsvc.sv
module wdg_vecsvc
    import wdg_pkg::*;
#(
    parameter int unsigned        ADDR_W     = 16,
    parameter int unsigned        DATA_W     = 8,
    parameter logic [ADDR_W-1:0]  SVC_ADDR   = '1,
    parameter logic [ADDR_W-1:0]  FETCH_ADDR = {{(ADDR_W-1){1'b1}}, 1'b0},
    parameter int unsigned        PRE_W      = 4,
    parameter int unsigned        SHORT_W    = 13,
    parameter int unsigned        LONG_W     = 18
) (
    input  logic              clk_i,
    input  logic              por_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] vec_lo_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rdata_en_o,
    input  logic              cfg_dis_i,
    input  logic              cfg_rate_i,
    input  logic [1:0]        lpm_i,
    input  logic              mon_entry_i,
    input  logic              tst_irq_i,
    input  logic              tst_rst_i,
    output logic              tmo_o
);
    bus_hit_t hit;
    logic     mon_blocked;
    logic     count_en;

    wdg_bus_dec #(
        .ADDR_W    (ADDR_W),
        .SVC_ADDR  (SVC_ADDR),
        .FETCH_ADDR(FETCH_ADDR)
    ) u_dec (
        .addr_i(addr_i),
        .rd_i  (rd_i),
        .wr_i  (wr_i),
        .hit_o (hit)
    );

    wdg_mon_gate u_mon (
        .clk_i      (clk_i),
        .por_n_i    (por_n_i),
        .mon_entry_i(mon_entry_i),
        .tst_irq_i  (tst_irq_i),
        .tst_rst_i  (tst_rst_i),
        .blocked_o  (mon_blocked)
    );

    always_comb begin
        count_en   = !cfg_dis_i && !mon_blocked && (lpm_i != LPM_STOP);
        rdata_en_o = hit.vsel;
        rdata_o    = hit.vsel ? vec_lo_i : '0;
    end

    wdg_count #(
        .PRE_W  (PRE_W),
        .SHORT_W(SHORT_W),
        .LONG_W (LONG_W)
    ) u_cnt (
        .clk_i  (clk_i),
        .por_n_i(por_n_i),
        .en_i   (count_en),
        .rate_i (cfg_rate_i),
        .svc_i  (hit.svc),
        .fetch_i(hit.fetch),
        .tmo_o  (tmo_o)
    );
endmodule

// File: rtl/wdg_vecsvc_chk.sv
module wdg_vecsvc_chk
    import wdg_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk_i,
    input logic              por_n_i,
    input logic              rd_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              rdata_en_o,
    input logic              cfg_dis_i,
    input logic [1:0]        lpm_i,
    input logic              mon_entry_i,
    input logic              tst_irq_i,
    input logic              tmo_o
);
    logic lat_seen_q;

    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i) begin
            lat_seen_q <= 1'b0;
        end else if (mon_entry_i && !tst_irq_i) begin
            lat_seen_q <= 1'b1;
        end
    end

    p_single_pulse_r4: assert property (@(posedge clk_i) disable iff (!por_n_i)
        tmo_o |=> !tmo_o);

    p_dis_quiet_r9: assert property (@(posedge clk_i) disable iff (!por_n_i)
        cfg_dis_i |=> !tmo_o);

    p_stop_quiet_r11: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (lpm_i == LPM_STOP) |=> !tmo_o);

    p_mon_latch_r13: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (lat_seen_q && $past(lat_seen_q)) |-> !tmo_o);

    p_rdata_idle_r8: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (!rd_i |-> (!rdata_en_o && rdata_o == '0)));
endmodule

bind wdg_vecsvc wdg_vecsvc_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_i      (clk_i),
    .por_n_i    (por_n_i),
    .rd_i       (rd_i),
    .rdata_o    (rdata_o),
    .rdata_en_o (rdata_en_o),
    .cfg_dis_i  (cfg_dis_i),
    .lpm_i      (lpm_i),
    .mon_entry_i(mon_entry_i),
    .tst_irq_i  (tst_irq_i),
    .tmo_o      (tmo_o)
);

// File: tb/wdg_vecsvc_tb.sv
module wdg_vecsvc_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PRE_W   = 4;
    localparam int SHORT_W = 7;
    localparam int LONG_W  = 10;
    localparam int T_LONG  = (1 << LONG_W) - (1 << PRE_W);   // 1008
    localparam int T_SHORT = (1 << SHORT_W) - (1 << PRE_W);  // 112

    logic        clk = 1'b0;
    logic        por_n;
    logic [15:0] addr;
    logic        rd, wr;
    logic [7:0]  vec_lo;
    logic [7:0]  rdata;
    logic        rdata_en;
    logic        cfg_dis, cfg_rate;
    logic [1:0]  lpm;
    logic        mon_entry, tst_irq, tst_rst;
    logic        tmo;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdg_vecsvc #(
        .PRE_W(PRE_W), .SHORT_W(SHORT_W), .LONG_W(LONG_W)
    ) u_dut (
        .clk_i(clk), .por_n_i(por_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
        .vec_lo_i(vec_lo), .rdata_o(rdata), .rdata_en_o(rdata_en),
        .cfg_dis_i(cfg_dis), .cfg_rate_i(cfg_rate), .lpm_i(lpm),
        .mon_entry_i(mon_entry), .tst_irq_i(tst_irq), .tst_rst_i(tst_rst),
        .tmo_o(tmo)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_por(input logic rate);
        @(negedge clk);
        por_n = 1'b0;
        addr = 16'h0000; rd = 1'b0; wr = 1'b0; vec_lo = 8'h00;
        cfg_dis = 1'b0; cfg_rate = rate; lpm = 2'b00;
        mon_entry = 1'b0; tst_irq = 1'b0; tst_rst = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
    endtask

    // edges until tmo seen high, sampled at falling edges
    task automatic edges_to_pulse(output int n);
        n = 0;
        for (int i = 0; i < 5000; i++) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (tmo) return;
        end
        n = -1;
    endtask

    // run n edges, report whether a pulse appeared
    task automatic run_quiet(input int n, output int seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (tmo) seen = 1;
        end
    endtask

    task automatic bus_cycle(input logic r, input logic w, input logic [15:0] a);
        addr = a; rd = r; wr = w;
        @(posedge clk);
        @(negedge clk);
        rd = 1'b0; wr = 1'b0; addr = 16'h0000;
    endtask

    task automatic t_reset;
        int n;
        do_por(1'b0);
        por_n = 1'b0;
        @(negedge clk);
        chk("R1 tmo in reset", tmo, 0);
        por_n = 1'b1;
        edges_to_pulse(n);
        chk("R1 count from zero after reset", n, T_LONG + 1);
    endtask

    task automatic t_long;
        int n;
        do_por(1'b0);
        lpm = 2'b01;  // wait mode still counts (R11)
        edges_to_pulse(n);
        chk("R2 long timeout, R11 wait counts", n, T_LONG + 1);
        edges_to_pulse(n);
        chk("R4 restart after long pulse", n, T_LONG + 1);
    endtask

    task automatic t_short;
        int n;
        do_por(1'b1);
        edges_to_pulse(n);
        chk("R3 short timeout", n, T_SHORT + 1);
        @(negedge clk);
        chk("R4 pulse one cycle", tmo, 0);
        edges_to_pulse(n);
        chk("R4 restart from zero", n, T_SHORT);
    endtask

    task automatic t_service;
        int n, s;
        do_por(1'b1);
        run_quiet(40, s);
        bus_cycle(1'b0, 1'b1, 16'hFFFF);   // count 41 -> low bits 9 kept
        edges_to_pulse(n);
        chk("R5 service keeps low bits", n, T_SHORT - 9 + 1);
    endtask

    task automatic t_fetch;
        int n, s;
        do_por(1'b1);
        run_quiet(40, s);
        bus_cycle(1'b1, 1'b0, 16'hFFFE);   // 41 -> 32
        bus_cycle(1'b0, 1'b1, 16'hFFFF);   // 33 -> 1
        edges_to_pulse(n);
        chk("R6 fetch clears prescaler", n, T_SHORT);
    endtask

    task automatic t_other_write;
        int n, s;
        do_por(1'b1);
        run_quiet(40, s);
        bus_cycle(1'b0, 1'b1, 16'h8000);
        edges_to_pulse(n);
        chk("R7 other write ignored", n, T_SHORT + 1 - 41);
    endtask

    task automatic t_read;
        vec_lo = 8'hA5;
        addr = 16'hFFFF; rd = 1'b1;
        #1;
        chk("R8 rdata at shared addr", int'(rdata), 8'hA5);
        chk("R8 rdata_en at shared addr", rdata_en, 1);
        addr = 16'h1234;
        #1;
        chk("R8 rdata_en elsewhere", rdata_en, 0);
        chk("R8 rdata elsewhere", int'(rdata), 0);
        addr = 16'hFFFF; rd = 1'b0;
        #1;
        chk("R8 no read strobe", rdata_en, 0);
        addr = 16'h0000;
    endtask

    task automatic t_disable;
        int n, s;
        do_por(1'b1);
        cfg_dis = 1'b1;
        run_quiet(500, s);
        chk("R9 no pulse while disabled", s, 0);
        cfg_dis = 1'b0;
        edges_to_pulse(n);
        chk("R9 count held while disabled", n, T_SHORT + 1);
    endtask

    task automatic t_rate_change;
        int n, s;
        do_por(1'b0);
        run_quiet(50, s);
        cfg_rate = 1'b1;
        edges_to_pulse(n);
        chk("R10 rate change applies at once", n, T_SHORT - 50 + 1);
    endtask

    task automatic t_stop;
        int n, s;
        do_por(1'b1);
        run_quiet(30, s);
        lpm = 2'b10;
        run_quiet(300, s);
        chk("R11 no pulse in stop", s, 0);
        lpm = 2'b00;
        edges_to_pulse(n);
        chk("R11 stop holds count", n, T_SHORT - 30 + 1);
    endtask

    task automatic t_mon_hold;
        int n, s;
        do_por(1'b1);
        mon_entry = 1'b1; tst_irq = 1'b1;
        @(posedge clk);
        @(negedge clk);
        mon_entry = 1'b0;
        run_quiet(300, s);
        chk("R12 held on test irq", s, 0);
        tst_irq = 1'b0; tst_rst = 1'b1;
        run_quiet(100, s);
        chk("R12 held on test reset pin", s, 0);
        tst_rst = 1'b0;
        edges_to_pulse(n);
        chk("R12 resumes after test voltage gone", n, T_SHORT + 1);
    endtask

    task automatic t_mon_latch;
        int n, s;
        do_por(1'b1);
        mon_entry = 1'b1;
        @(posedge clk);
        @(negedge clk);
        mon_entry = 1'b0;
        run_quiet(500, s);
        chk("R13 latched disable", s, 0);
        do_por(1'b1);
        edges_to_pulse(n);
        chk("R13 cleared by power-on reset", n, T_SHORT + 1);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_long();
        t_short();
        t_service();
        t_fetch();
        t_other_write();
        t_read();
        t_disable();
        t_rate_change();
        t_stop();
        t_mon_hold();
        t_mon_latch();
        finish_run();
    end
endmodule